// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block keeps the byte count for a DMA transfer and turns it into the length of each burst. Software writes the count one byte at a time into a shadow copy. Any command issued with the DMA bit set copies the shadow into the active count. A transfer command with the DMA bit set starts a burst. The burst length is the smaller of the active count and a cap. The cap is 32 bytes in command phase. In a data phase it is the magnitude of the signed remaining data size. An active count of zero stands for 65536 bytes.

Once a burst is running, each accepted beat lowers the remaining length. When the length reaches zero the block pulses a done signal, sets the count-zero status and clears the active count. A transfer command that arrives while the DMA enable input is low is held. It starts when the enable input rises.

Top module: `dlc_xfer_counter`

## Requirements
- R1: A write with `cnt_sel_i` = 0, 1 or 2 stores `cnt_wdata_i` as bits [7:0], [15:8] or [23:16] of the shadow count. A write on its own leaves `count_o` unchanged.
- R2: A command (`cmd_valid_i`) with `cmd_dma_i`=1 copies the shadow count into `count_o` on the next cycle, whether or not it is a transfer command. A command with `cmd_dma_i`=0 leaves `count_o` unchanged and starts no burst.
- R3: When a burst starts and the active count is zero, the count is taken as 65536.
- R4: When `cmd_phase_i`=1 at the start, the burst length is the smaller of the count and 32.
- R5: When `cmd_phase_i`=0 at the start, the burst length is the smaller of the count and the magnitude of the two's-complement `rem_size_i`. `dir_to_dev_o` is 1 exactly when `rem_size_i` is negative.
- R6: In the cycle after a start with nonzero length, `busy_o`=1, `tc_o`=0, and both `burst_len_o` and `remaining_o` equal the computed length.
- R7: While `busy_o`=1, each cycle with `beat_valid_i` lowers `remaining_o` by the smaller of `beat_bytes_i` and `remaining_o`.
- R8: When `remaining_o` reaches zero, `done_o` is high for that one cycle, together with `tc_o`=1, `count_o`=0 and `busy_o`=0. A start with zero length gives this state in the cycle right after the start.
- R9: A transfer command with `cmd_dma_i`=1 while `dma_en_i`=0 starts no burst and still reloads the count. It starts on the first clock where `dma_en_i` is seen rising, using the reloaded count.
- R10: After reset, `count_o`, `burst_len_o` and `remaining_o` are 0, and `busy_o`, `tc_o`, `done_o` and `dir_to_dev_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_we_i | input | 1 | Shadow count byte write strobe |
| cnt_sel_i | input | SEL_W (2) | Byte lane of the shadow count |
| cnt_wdata_i | input | 8 | Byte to write |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_dma_i | input | 1 | DMA bit of the command |
| cmd_xfer_i | input | 1 | Command is a transfer command |
| dma_en_i | input | 1 | DMA enable level |
| cmd_phase_i | input | 1 | Bus is in command phase |
| rem_size_i | input | SIZE_W (25) | Signed remaining data size; negative means toward the device |
| beat_valid_i | input | 1 | A beat was accepted this cycle |
| beat_bytes_i | input | BEAT_W (8) | Bytes carried by the beat |
| count_o | output | CNT_W (24) | Active transfer count |
| burst_len_o | output | LEN_W (25) | Length of the current burst |
| remaining_o | output | LEN_W (25) | Bytes left in the burst |
| busy_o | output | 1 | Burst in progress |
| dir_to_dev_o | output | 1 | Burst moves data toward the device |
| tc_o | output | 1 | Count-zero status |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: three count bytes, a 25-bit signed size, 8-bit beats and a 32-byte command cap. With a 25-bit size, data-phase magnitudes above 65536 are possible, so the zero-count substitution becomes the limiting term. With 8-bit beats, a full 65536-byte burst drains in 258 beats, which keeps the largest burst short enough to run to completion. Negative sizes whose magnitude sets the length, and a zero-length data burst, are also within reach of these widths.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {LANE_LO = 2'd0, LANE_MID = 2'd1, LANE_HI = 2'd2} lane_e;
endpackage

// File: rtl/dlc_count_regs.sv
module dlc_count_regs
  import dlc_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int SEL_W     = 2,
  localparam int CNT_W    = BYTE_W * CNT_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              reload_i,
  input  logic              clear_i,
  output logic [CNT_W-1:0]  shadow_o,
  output logic [CNT_W-1:0]  active_o
);
  logic [BYTE_W-1:0] sh_q [CNT_BYTES];
  logic [CNT_W-1:0]  act_q;

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          sh_q[b] <= '0;
      else if (we_i && sel_i == SEL_W'(b))  sh_q[b] <= wdata_i;
    end
    assign shadow_o[b*BYTE_W +: BYTE_W] = sh_q[b];
  end

  // clear wins: completion (incl. zero-length start) empties the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_q <= '0;
    else if (clear_i)  act_q <= '0;
    else if (reload_i) act_q <= shadow_o;
  end

  assign active_o = act_q;
endmodule

// File: rtl/dlc_burst_calc.sv
module dlc_burst_calc #(
  parameter int CNT_W    = 24,
  parameter int SIZE_W   = 25,
  parameter int LEN_W    = 25,
  parameter int CMD_CAP  = 32,
  parameter int ZERO_LEN = 65536,
  localparam int CMP_W   = (SIZE_W > LEN_W) ? SIZE_W : LEN_W
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cmd_phase_i,
  input  logic [SIZE_W-1:0] rem_size_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              to_dev_o
);
  logic [CMP_W-1:0]  eff, cap, pick;
  logic [SIZE_W-1:0] mag;

  always_comb begin
    to_dev_o = rem_size_i[SIZE_W-1];
    mag      = to_dev_o ? (~rem_size_i) + SIZE_W'(1) : rem_size_i;
    eff      = (cnt_i == '0) ? CMP_W'(ZERO_LEN) : CMP_W'(cnt_i);
    cap      = cmd_phase_i ? CMP_W'(CMD_CAP) : CMP_W'(mag);
    pick     = (eff < cap) ? eff : cap;
    len_o    = LEN_W'(pick);
  end
endmodule

// File: rtl/dlc_beat_track.sv
module dlc_beat_track #(
  parameter int LEN_W  = 25,
  parameter int BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  output logic              finish_o,
  output logic [LEN_W-1:0]  remaining_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [LEN_W-1:0] rem_q, take, rem_n;
  logic             busy_q, done_q;

  always_comb begin
    take     = (LEN_W'(beat_bytes_i) < rem_q) ? LEN_W'(beat_bytes_i) : rem_q;
    rem_n    = rem_q - take;
    finish_o = start_i ? (start_len_i == '0)
                       : (busy_q && beat_valid_i && rem_n == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_o;
      if (start_i) begin
        rem_q  <= start_len_i;
        busy_q <= (start_len_i != '0);
      end else if (busy_q && beat_valid_i) begin
        rem_q  <= rem_n;
        busy_q <= (rem_n != '0);
      end
    end
  end

  assign remaining_o = rem_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
endmodule

// File: rtl/dlc_xfer_counter.sv
module dlc_xfer_counter
  import dlc_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int SIZE_W    = 25,
  parameter int BEAT_W    = 8,
  parameter int CMD_CAP   = 32,
  parameter int ZERO_LEN  = 65536,
  localparam int CNT_W    = BYTE_W * CNT_BYTES,
  localparam int SEL_W    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1,
  localparam int LEN_W    = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_we_i,
  input  logic [SEL_W-1:0]  cnt_sel_i,
  input  logic [BYTE_W-1:0] cnt_wdata_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_dma_i,
  input  logic              cmd_xfer_i,
  input  logic              dma_en_i,
  input  logic              cmd_phase_i,
  input  logic [SIZE_W-1:0] rem_size_i,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [LEN_W-1:0]  burst_len_o,
  output logic [LEN_W-1:0]  remaining_o,
  output logic              busy_o,
  output logic              dir_to_dev_o,
  output logic              tc_o,
  output logic              done_o
);
  logic [CNT_W-1:0] shadow, active, start_cnt;
  logic [LEN_W-1:0] len, len_q;
  logic reload, xfer_go, start_now, start_pend, start, finish, to_dev;
  logic en_q, pend_q, tc_q, dir_q;

  assign reload     = cmd_valid_i && cmd_dma_i;
  assign xfer_go    = reload && cmd_xfer_i;
  assign start_now  = xfer_go && dma_en_i;
  assign start_pend = pend_q && dma_en_i && !en_q;
  assign start      = start_now || start_pend;
  // a fresh command sees the shadow value that reload is copying this cycle
  assign start_cnt  = start_now ? shadow : active;

  dlc_count_regs #(.CNT_BYTES(CNT_BYTES), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cnt_we_i), .sel_i(cnt_sel_i), .wdata_i(cnt_wdata_i),
    .reload_i(reload), .clear_i(finish),
    .shadow_o(shadow), .active_o(active)
  );

  dlc_burst_calc #(
    .CNT_W(CNT_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W),
    .CMD_CAP(CMD_CAP), .ZERO_LEN(ZERO_LEN)
  ) u_calc (
    .cnt_i(start_cnt), .cmd_phase_i, .rem_size_i,
    .len_o(len), .to_dev_o(to_dev)
  );

  dlc_beat_track #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_track (
    .clk_i, .rst_ni,
    .start_i(start), .start_len_i(len),
    .beat_valid_i, .beat_bytes_i,
    .finish_o(finish), .remaining_o, .busy_o, .done_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      tc_q   <= 1'b0;
      len_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      en_q <= dma_en_i;
      if (xfer_go && !dma_en_i) pend_q <= 1'b1;
      else if (start)           pend_q <= 1'b0;
      if (finish)     tc_q <= 1'b1;
      else if (start) tc_q <= 1'b0;
      if (start) begin
        len_q <= len;
        dir_q <= to_dev;
      end
    end
  end

  assign count_o      = active;
  assign burst_len_o  = len_q;
  assign dir_to_dev_o = dir_q;
  assign tc_o         = tc_q;
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int LEN_W   = 25,
  parameter int CNT_W   = 24,
  parameter int BEAT_W  = 8,
  parameter int CMD_CAP = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              dma_en_i,
  input logic              cmd_phase_i,
  input logic              beat_valid_i,
  input logic [BEAT_W-1:0] beat_bytes_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [LEN_W-1:0]  burst_len_o,
  input logic [LEN_W-1:0]  remaining_o,
  input logic              busy_o,
  input logic              tc_o,
  input logic              done_o
);
  assert_done_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tc_o && count_o == '0 && !busy_o && remaining_o == '0));

  assert_tc_only_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> done_o);

  assert_start_clears_tc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tc_o);

  assert_cmd_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(cmd_phase_i)) |-> burst_len_o <= LEN_W'(CMD_CAP));

  assert_beat_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && beat_valid_i && !cmd_valid_i && !(dma_en_i && !$past(dma_en_i))
     && LEN_W'(beat_bytes_i) < remaining_o)
    |=> remaining_o == $past(remaining_o) - LEN_W'($past(beat_bytes_i)));

  assert_busy_bounds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (remaining_o != '0 && remaining_o <= burst_len_o));
endmodule

bind dlc_xfer_counter dlc_checker #(
  .LEN_W(LEN_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W), .CMD_CAP(CMD_CAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .dma_en_i(dma_en_i), .cmd_phase_i(cmd_phase_i),
  .beat_valid_i(beat_valid_i), .beat_bytes_i(beat_bytes_i),
  .count_o(count_o), .burst_len_o(burst_len_o), .remaining_o(remaining_o),
  .busy_o(busy_o), .tc_o(tc_o), .done_o(done_o)
);

// File: tb/dlc_xfer_counter_bench.sv
module dlc_xfer_counter_bench;
  import dlc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_we = 1'b0;
  logic [1:0]  cnt_sel = '0;
  logic [7:0]  cnt_wdata = '0;
  logic        cmd_valid = 1'b0, cmd_dma = 1'b0, cmd_xfer = 1'b0;
  logic        dma_en = 1'b1, cmd_phase = 1'b0;
  logic [24:0] rem_size = '0;
  logic        beat_valid = 1'b0;
  logic [7:0]  beat_bytes = '0;
  logic [23:0] count;
  logic [24:0] burst_len, remaining;
  logic        busy, dir_to_dev, tc, done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dlc_xfer_counter u_dlc_xfer_counter (
    .clk_i(clk), .rst_ni(rst_n),
    .cnt_we_i(cnt_we), .cnt_sel_i(cnt_sel), .cnt_wdata_i(cnt_wdata),
    .cmd_valid_i(cmd_valid), .cmd_dma_i(cmd_dma), .cmd_xfer_i(cmd_xfer),
    .dma_en_i(dma_en), .cmd_phase_i(cmd_phase), .rem_size_i(rem_size),
    .beat_valid_i(beat_valid), .beat_bytes_i(beat_bytes),
    .count_o(count), .burst_len_o(burst_len), .remaining_o(remaining),
    .busy_o(busy), .dir_to_dev_o(dir_to_dev), .tc_o(tc), .done_o(done)
  );

  typedef struct packed {
    logic [23:0] cnt;
    logic        phase;
    logic [24:0] size;
    logic [24:0] len;
    logic [23:0] cnt_after;
    logic        dir;
  } vec_t;

  // R3 R4 R5 cases: count, phase, signed size -> length, count after start, direction
  localparam vec_t VECS [8] = '{
    '{24'h000100, 1'b0, 25'h0000040,  25'h0000040, 24'h000100, 1'b0},
    '{24'h000010, 1'b0, 25'h0000100,  25'h0000010, 24'h000010, 1'b0},
    '{24'h000000, 1'b0, 25'h0020000,  25'h0010000, 24'h000000, 1'b0},
    '{24'h000000, 1'b1, 25'h0000000,  25'h0000020, 24'h000000, 1'b0},
    '{24'h000005, 1'b1, 25'h0000000,  25'h0000005, 24'h000005, 1'b0},
    '{24'h123456, 1'b0, -25'sd768,    25'h0000300, 24'h123456, 1'b1},
    '{24'h0000FF, 1'b0, -25'sd4096,   25'h00000FF, 24'h0000FF, 1'b1},
    '{24'h000010, 1'b0, 25'h0000000,  25'h0000000, 24'h000000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_count(input logic [23:0] v);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      cnt_we    = 1'b1;
      cnt_sel   = 2'(b);
      cnt_wdata = v[b*8 +: 8];
    end
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic issue(input logic dma, input logic xfer);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_dma   = dma;
    cmd_xfer  = xfer;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    cmd_dma   = 1'b0;
    cmd_xfer  = 1'b0;
  endtask

  // feeds beats of 'step' bytes until remaining hits zero; checks the done cycle
  task automatic drain(input int len, input int step, input string req);
    int beats = 0;
    while (remaining != '0 && beats < 70000) begin
      @(negedge clk);
      beat_valid = 1'b1;
      beat_bytes = 8'(step);
      @(posedge clk);
      #1;
      beats++;
    end
    beat_valid = 1'b0;
    check({req, " beats"}, beats, (len + step - 1) / step);
    check({req, " done"}, done, 1);
    check({req, " tc"}, tc, 1);
    check({req, " count cleared"}, count, 0);
    check({req, " busy low"}, busy, 0);
    @(posedge clk);
    #1;
    check({req, " done one cycle"}, done, 0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 count", count, 0);
    check("R10 burst_len", burst_len, 0);
    check("R10 remaining", remaining, 0);
    check("R10 flags", {busy, tc, done, dir_to_dev}, 0);

    // R1 byte lanes, no effect until reload
    write_count(24'hABCDEF);
    @(posedge clk);
    #1;
    check("R1 write alone keeps count", count, 0);
    // R2 non-transfer command with DMA bit reloads
    issue(1'b1, 1'b0);
    check("R1 R2 reload lane order", count, 24'hABCDEF);
    check("R2 no burst on reload", busy, 0);
    // R2 DMA bit clear: ignored
    write_count(24'h000111);
    cmd_phase = 1'b0;
    rem_size  = 25'h40;
    issue(1'b0, 1'b1);
    @(posedge clk);
    #1;
    check("R2 count kept without DMA bit", count, 24'hABCDEF);
    check("R2 no burst without DMA bit", busy, 0);

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < 8; i++) begin
      write_count(VECS[i].cnt);
      cmd_phase = VECS[i].phase;
      rem_size  = VECS[i].size;
      issue(1'b1, 1'b1);
      check($sformatf("R3 R4 R5 vec%0d burst_len", i), burst_len, VECS[i].len);
      check($sformatf("R5 vec%0d direction", i), dir_to_dev, VECS[i].dir);
      check($sformatf("R2 vec%0d count", i), count, VECS[i].cnt_after);
      if (VECS[i].len != 0) begin
        check($sformatf("R6 vec%0d busy tc", i), {busy, tc}, 2'b10);
        check($sformatf("R6 vec%0d remaining", i), remaining, VECS[i].len);
        drain(int'(VECS[i].len), 255, $sformatf("R8 vec%0d", i));
      end else begin
        check("R8 zero-length done", {done, tc, busy}, 3'b110);
        @(posedge clk);
        #1;
        check("R8 zero-length pulse", done, 0);
      end
      @(posedge clk);
    end

    // R9 pending while DMA disabled
    @(negedge clk);
    dma_en = 1'b0;
    write_count(24'h000040);
    cmd_phase = 1'b0;
    rem_size  = 25'h80;
    issue(1'b1, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    check("R9 held while disabled", busy, 0);
    check("R9 count reloaded while held", count, 24'h000040);
    @(negedge clk);
    dma_en = 1'b1;
    @(posedge clk);
    #1;
    check("R9 starts on enable rise", busy, 1);
    check("R9 burst_len", burst_len, 25'h40);
    drain(64, 255, "R9");

    // R7 partial beats, oversized last beat
    write_count(24'h000009);
    cmd_phase = 1'b1;
    issue(1'b1, 1'b1);
    @(negedge clk);
    beat_valid = 1'b1;
    beat_bytes = 8'd3;
    @(posedge clk);
    #1;
    check("R7 step by beat", remaining, 6);
    @(negedge clk);
    beat_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R7 idle beat keeps remaining", remaining, 6);
    @(negedge clk);
    beat_valid = 1'b1;
    beat_bytes = 8'd200;
    @(posedge clk);
    #1;
    beat_valid = 1'b0;
    check("R7 oversize beat clamps", remaining, 0);
    check("R8 done after clamp", {done, tc, busy}, 3'b110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule